// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers the interrupt sources of a network controller into one 32-bit cause register, gates them with a 32-bit mask register, and drives a single level-sensitive interrupt line. Hardware events (transmit done, transmit queue empty, receive overrun, and completion of a PHY management access) arrive as one-cycle pulses and set their own cause bits. Software reaches the block through a simple single-cycle register port with four word addresses.

A read of the cause address returns the pending causes and empties the register in the same access, so a handler sees every cause exactly once. Software can also clear chosen causes by writing ones to the cause address, raise causes itself through a cause-set address, and change the mask through separate set and clear addresses, so no read-modify-write is ever needed. The top cause bit is a summary flag that is set whenever any cause is pending; enabling it in the mask turns the line into "any cause pending".

Top module: `irq_cause_ctl`

## Requirements
- R1: While reset is asserted and right after it, the cause and mask registers are zero and `irq` is low; the first read of the cause address (0) and of the mask address (2) after reset both return 0.
- R2: `irq` is high exactly when the bitwise AND of the mask register and the cause register is nonzero, and it follows a register change in the same cycle the register changes.
- R3: A write to address 1 (cause set) ORs `reg_wdata` into the cause register at the next clock edge; a write of zero changes nothing.
- R4: Whenever the stored cause value is nonzero, bit 31 (summary) is set in it; when every cause bit including bit 31 is cleared the register is zero.
- R5: A read of address 0 presents the cause value held before the read on `reg_rdata` one cycle later and clears the whole cause register at the same edge, so `irq` drops unless an event arrives in that cycle.
- R6: A write to address 0 clears each cause bit written as 1 and leaves the others unchanged; bit 31 stays set while any cause remains.
- R7: A write to address 2 (mask set) ORs `reg_wdata` into the mask; a read of address 2 returns the mask one cycle later and changes nothing.
- R8: A write to address 3 (mask clear) clears each mask bit written as 1.
- R9: Event pulses set fixed cause bits: `evt_i[0]` (transmit done) bit 0, `evt_i[1]` (transmit queue empty) bit 1, `evt_i[2]` (receive overrun) bit 6, and `mgmt_done` (PHY management access complete) bit 9.
- R10: An event pulse in the same cycle as a software clear or a read-clear wins: its cause bit is set afterwards.
- R11: Reads of addresses 1 and 3 return 0 and change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_addr | input | 2 | Word address: 0 cause, 1 cause set, 2 mask set, 3 mask clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd`, otherwise 0 |
| evt_i | input | 3 | Event pulses: transmit done, queue empty, receive overrun |
| mgmt_done | input | 1 | Pulse on completion of a PHY management access |
| irq | output | 1 | Level interrupt line |

## Verification
The bench targets the summary bit: a controller that forgets to set bit 31 would leave the line low when only the summary is enabled, and one that keeps it set after a full clear would hold the line high forever. It collides event pulses with a read-clear and a write-clear; a design that lets the clear win loses an interrupt silently, which shows up when the next read returns zero. It checks that reads of the mask and of the unused addresses leave the causes intact, since a decoder that clears on any read would drop pending work, and that masking hides a cause from the line without erasing it.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    // Register width of cause and mask
    localparam int unsigned IRQ_W = 32;

    // Word addresses of the register port
    typedef enum logic [1:0] {
        ADR_CAUSE = 2'd0,   // read: fetch and clear, write: clear ones
        ADR_CSET  = 2'd1,   // write: OR into causes
        ADR_MSET  = 2'd2,   // write: OR into mask, read: mask value
        ADR_MCLR  = 2'd3    // write: clear mask ones
    } irq_addr_e;

    // Default cause positions of the hardware events
    localparam int unsigned N_EVT_DEF   = 3;
    localparam int unsigned POS_TXDONE  = 0;
    localparam int unsigned POS_TXEMPTY = 1;
    localparam int unsigned POS_RXOVR   = 6;
    localparam int unsigned POS_MGMT    = 9;

    // Read data selection
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_CAUSE = 2'd1,
        RSEL_MASK  = 2'd2
    } irq_rsel_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W = IRQ_W,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] sw_set,
    output logic [DATA_W-1:0] sw_clr,
    output logic [DATA_W-1:0] msk_set,
    output logic [DATA_W-1:0] msk_clr,
    output irq_rsel_e         rsel
);

    irq_addr_e adr;
    assign adr = irq_addr_e'(reg_addr);

    always_comb begin
        sw_set  = '0;
        sw_clr  = '0;
        msk_set = '0;
        msk_clr = '0;
        rsel    = RSEL_NONE;

        if (reg_wr) begin
            unique case (adr)
                ADR_CAUSE: sw_clr  = reg_wdata;
                ADR_CSET:  sw_set  = reg_wdata;
                ADR_MSET:  msk_set = reg_wdata;
                ADR_MCLR:  msk_clr = reg_wdata;
                default:   ;
            endcase
        end

        if (reg_rd) begin
            unique case (adr)
                ADR_CAUSE: begin
                    rsel   = RSEL_CAUSE;
                    sw_clr = '1;          // fetch empties the register
                end
                ADR_MSET:  rsel = RSEL_MASK;
                default:   rsel = RSEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irq_event_map.sv
module irq_event_map
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W            = IRQ_W,
    parameter int unsigned N_EVT             = N_EVT_DEF,
    parameter int unsigned EVT_POS [N_EVT]   = '{POS_TXDONE, POS_TXEMPTY, POS_RXOVR},
    parameter int unsigned MGMT_POS          = POS_MGMT
) (
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              mgmt_done,
    output logic [DATA_W-1:0] hw_set
);

    logic [DATA_W-1:0] one_evt [N_EVT];
    logic [DATA_W-1:0] mgmt_vec;

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        always_comb begin
            one_evt[g]             = '0;
            one_evt[g][EVT_POS[g]] = evt_i[g];
        end
    end

    always_comb begin
        mgmt_vec           = '0;
        mgmt_vec[MGMT_POS] = mgmt_done;
    end

    always_comb begin
        hw_set = mgmt_vec;
        for (int i = 0; i < int'(N_EVT); i++) begin
            hw_set = hw_set | one_evt[i];
        end
    end

endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W = IRQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hw_set,
    input  logic [DATA_W-1:0] sw_set,
    input  logic [DATA_W-1:0] sw_clr,
    input  logic [DATA_W-1:0] msk_set,
    input  logic [DATA_W-1:0] msk_clr,
    input  irq_rsel_e         rsel,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int unsigned SUM_POS = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] cause_tmp;

    always_comb begin
        st_d = st_q;

        // clear first, then set: events and set writes win
        cause_tmp = (st_q.cause & ~sw_clr) | sw_set | hw_set;
        if (|cause_tmp) begin
            cause_tmp[SUM_POS] = 1'b1;
        end
        st_d.cause = cause_tmp;

        st_d.mask = (st_q.mask & ~msk_clr) | msk_set;

        unique case (rsel)
            RSEL_CAUSE: st_d.rdata = st_q.cause;
            RSEL_MASK:  st_d.rdata = st_q.mask;
            default:    st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign rdata_o = st_q.rdata;
    assign irq_o   = |(st_q.cause & st_q.mask);

endmodule

// File: rtl/irq_cause_ctl.sv
module irq_cause_ctl
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W   = IRQ_W,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned N_EVT    = N_EVT_DEF,
    parameter int unsigned MGMT_POS = POS_MGMT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              mgmt_done,
    output logic              irq
);

    logic [DATA_W-1:0] sw_set, sw_clr, msk_set, msk_clr, hw_set;
    logic [DATA_W-1:0] cause_w, mask_w;
    irq_rsel_e         rsel;

    irq_bus_decode #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .msk_set   (msk_set),
        .msk_clr   (msk_clr),
        .rsel      (rsel)
    );

    irq_event_map #(
        .DATA_W   (DATA_W),
        .N_EVT    (N_EVT),
        .MGMT_POS (MGMT_POS)
    ) u_map (
        .evt_i     (evt_i),
        .mgmt_done (mgmt_done),
        .hw_set    (hw_set)
    );

    irq_cause_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .msk_set (msk_set),
        .msk_clr (msk_clr),
        .rsel    (rsel),
        .cause_o (cause_w),
        .mask_o  (mask_w),
        .rdata_o (reg_rdata),
        .irq_o   (irq)
    );

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned N_EVT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_EVT-1:0]  evt_i,
    input logic              mgmt_done,
    input logic              irq,
    input logic [DATA_W-1:0] cause,
    input logic [DATA_W-1:0] mask
);

    logic quiet_hw;
    assign quiet_hw = (evt_i == '0) && !mgmt_done;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!irq && cause == '0 && mask == '0));                              // R1

    AST_LINE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cause != '0 && mask != '0));                                         // R2

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> ((cause & $past(reg_wdata)) == $past(reg_wdata))); // R3

    AST_SUMMARY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0) |-> cause[DATA_W-1]);                                           // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 2'd0 && quiet_hw)
        |=> (reg_rdata == $past(cause) && cause == '0 && !irq));                     // R5

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == 2'd0 && quiet_hw)
        |=> ((cause & $past(reg_wdata) & {1'b0, {(DATA_W-1){1'b1}}}) == '0));        // R6

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata))); // R7

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> ((mask & $past(reg_wdata)) == '0));          // R8

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> cause[0]);                                                       // R10

    AST_MGMT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_done |=> cause[9]);                                                      // R9

    AST_DEAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr[0]) |=> (reg_rdata == '0));                    // R11

endmodule

bind irq_cause_ctl irq_cause_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_EVT  (N_EVT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_i     (evt_i),
    .mgmt_done (mgmt_done),
    .irq       (irq),
    .cause     (cause_w),
    .mask      (mask_w)
);

// File: tb/irq_cause_ctl_bench.sv
module irq_cause_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  evt_i = '0;
    logic        mgmt_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_cause_ctl u_irq_cause_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt_i),
        .mgmt_done (mgmt_done),
        .irq       (irq)
    );

    // op: 0 idle, 1 write, 2 read
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [2:0]  evt;
        logic        mgmt;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd1, 32'h0000_0005, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd3},  // R3 set
        '{2'd2, 2'd0, 32'h0,         3'b000, 1'b0, 1'b1, 32'h8000_0005,  1'b0, 4'd4},  // R4 summary seen
        '{2'd1, 2'd2, 32'h0000_0004, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd7},  // R7 mask set
        '{2'd1, 2'd1, 32'h0000_0001, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd2},  // R2 masked out
        '{2'd1, 2'd1, 32'h0000_0004, 3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd2},  // R2 line up
        '{2'd1, 2'd0, 32'h0000_0004, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd6},  // R6 partial clear
        '{2'd2, 2'd2, 32'h0,         3'b000, 1'b0, 1'b1, 32'h0000_0004,  1'b0, 4'd7},  // R7 mask read
        '{2'd1, 2'd2, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd4},  // R4 summary enables
        '{2'd2, 2'd1, 32'h0,         3'b000, 1'b0, 1'b1, 32'h0,          1'b1, 4'd11}, // R11 dead read
        '{2'd2, 2'd0, 32'h0,         3'b000, 1'b0, 1'b1, 32'h8000_0001,  1'b0, 4'd5},  // R5 read clear
        '{2'd0, 2'd0, 32'h0,         3'b100, 1'b0, 1'b0, 32'h0,          1'b1, 4'd9},  // R9 rx overrun
        '{2'd1, 2'd3, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd8},  // R8 mask clear
        '{2'd0, 2'd0, 32'h0,         3'b000, 1'b1, 1'b0, 32'h0,          1'b0, 4'd9},  // R9 mgmt done
        '{2'd1, 2'd2, 32'h0000_0200, 3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd9},  // R9 bit 9 live
        '{2'd1, 2'd0, 32'h8000_0240, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd4},  // R4 full clear
        '{2'd1, 2'd0, 32'h0000_0001, 3'b001, 1'b0, 1'b0, 32'h0,          1'b0, 4'd10}, // R10 vs write clear
        '{2'd2, 2'd0, 32'h0,         3'b010, 1'b0, 1'b1, 32'h8000_0001,  1'b0, 4'd10}, // R10 vs read clear
        '{2'd2, 2'd0, 32'h0,         3'b000, 1'b0, 1'b1, 32'h8000_0002,  1'b0, 4'd10}, // R10 survivor
        '{2'd1, 2'd1, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 32'h0,          1'b0, 4'd3},  // R3 set summary only
        '{2'd1, 2'd2, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd7},  // R7 mask OR
        '{2'd1, 2'd0, 32'h0,         3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd6},  // R6 zero write
        '{2'd2, 2'd3, 32'h0,         3'b000, 1'b0, 1'b1, 32'h0,          1'b1, 4'd11}, // R11 dead read 3
        '{2'd1, 2'd1, 32'h0,         3'b000, 1'b0, 1'b0, 32'h0,          1'b1, 4'd3},  // R3 zero set
        '{2'd2, 2'd0, 32'h0,         3'b000, 1'b0, 1'b1, 32'h8000_0000,  1'b0, 4'd5}   // R5 read clear
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after a falling edge, results sampled at the next falling edge
    task automatic step(input logic [1:0] op, input logic [1:0] addr,
                        input logic [31:0] wd, input logic [2:0] ev, input logic mg);
        reg_wr    = (op == 2'd1);
        reg_rd    = (op == 2'd2);
        reg_addr  = addr;
        reg_wdata = wd;
        evt_i     = ev;
        mgmt_done = mg;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_wdata = '0;
        evt_i     = '0;
        mgmt_done = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: quiet during reset and after it
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        step(2'd2, 2'd0, '0, '0, 1'b0);
        check(reg_rdata == 32'h0, "R1 cause after reset", reg_rdata, 32'h0);
        step(2'd2, 2'd2, '0, '0, 1'b0);
        check(reg_rdata == 32'h0, "R1 mask after reset", reg_rdata, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].mgmt);
            if (VEC[i].chk_rd) begin
                check(reg_rdata == VEC[i].exp_rd, $sformatf("R%0d rdata vec %0d", VEC[i].req, i),
                      reg_rdata, VEC[i].exp_rd);
            end
            check(irq == VEC[i].exp_irq, $sformatf("R%0d irq vec %0d", VEC[i].req, i),
                  {31'b0, irq}, {31'b0, VEC[i].exp_irq});
        end

        // R9: transmit events land on bits 0 and 1
        step(2'd0, 2'd0, '0, 3'b011, 1'b0);
        step(2'd2, 2'd0, '0, '0, 1'b0);
        check(reg_rdata == 32'h8000_0003, "R9 tx event bits", reg_rdata, 32'h8000_0003);

        // R2: line follows mask removal the same cycle the mask changes
        step(2'd1, 2'd2, 32'h0000_0040, '0, 1'b0);
        step(2'd1, 2'd1, 32'h0000_0040, '0, 1'b0);
        check(irq == 1'b1, "R2 line on", {31'b0, irq}, 32'h1);
        step(2'd1, 2'd3, 32'hFFFF_FFFF, '0, 1'b0);
        check(irq == 1'b0, "R2 line off after mask clear", {31'b0, irq}, 32'h0);
        step(2'd2, 2'd0, '0, '0, 1'b0);
        check(reg_rdata == 32'h8000_0040, "R8 masking keeps cause", reg_rdata, 32'h8000_0040);

        // R1: reset mid-run wipes state
        step(2'd1, 2'd1, 32'h0000_0001, '0, 1'b0);
        step(2'd1, 2'd2, 32'h0000_0001, '0, 1'b0);
        check(irq == 1'b1, "R1 line before reset", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        #1;
        check(irq == 1'b0, "R1 reset drops line", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(2'd2, 2'd2, '0, '0, 1'b0);
        check(reg_rdata == 32'h0, "R1 mask zero after reset", reg_rdata, 32'h0);
        step(2'd2, 2'd0, '0, '0, 1'b0);
        check(reg_rdata == 32'h0, "R1 cause zero after reset", reg_rdata, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule